// File: doc/BRIEF.md
# Quadrature Position Counter with Index

This block turns the two phase signals of an incremental rotary or linear encoder into a position count. The count lives inside a programmable window between a lower and an upper bound. Each time the count leaves the window at one end, it re-enters at the other end. A signed wrap counter records how many times this has happened in each direction. The decoder can produce one, two or four counts for each full quadrature cycle.

Two strobes act on the counters in different ways:
- An index strobe, typically the once-per-turn marker, snaps the position to the lower bound and steps the wrap counter.
- A home (reset) strobe reloads the position with a programmed start value and leaves the wrap counter unchanged.

A compare register drives a match output that stays high while the position equals it. Five sticky event flags record home, index, match, roll-over and roll-under events for software.

All four inputs are synchronised and pass through a glitch filter with a programmable stability count. Software uses a single write port to load the position, the wrap counter, the window, the start value and the compare value, and to clear the flags.

Top module: `qpos_counter`

## Requirements
- R1: `res_sel` picks the resolution: 0 gives 1 count per cycle, 1 gives 2, and 2 or 3 give 4. The phase order {B,A} = 00, 01, 11, 10 counts up and the reverse order counts down. At 1 count per cycle, only the 00↔01 transition counts. At 2 counts per cycle, only transitions that change A count. A jump of two phases is ignored.
- R2: An up count with the position at or above the effective upper bound loads the start value, adds 1 to `cycles` and sets `flags[3]` (roll-over).
- R3: A down count with the position at or below the lower bound loads the effective upper bound, subtracts 1 from `cycles` and sets `flags[4]` (roll-under).
- R4: A write to address 1 loads `cycles` (signed, 16 bits by default) and leaves the position unchanged. From the next cycle, `cyc_prev` holds the value `cycles` had before the write.
- R5: With `idx_en` high, a rising edge on `in_index` loads the lower bound into the position, steps `cycles` by +1 if the last valid phase move was upward (the state after reset) or by −1 otherwise, and sets `flags[1]`.
- R6: With `rst_en` high, a rising edge on `in_reset` loads the start value into the position, leaves `cycles` unchanged and sets `flags[0]`.
- R7: `match_out` is high exactly while the position equals the compare register, also when that value lies outside the window. Every cycle in which the two are equal sets `flags[2]`.
- R8: Flags stay set until software writes to address 6 with a 1 in the flag's bit. An event in the same cycle as the clear keeps the flag set.
- R9: An input change is accepted only after it has been present at the synchroniser output for `filt_len`+1 consecutive clocks. A shorter pulse has no effect. A `filt_len` of 0 accepts every change one clock after synchronisation.
- R10: When both bounds are 0, the effective upper bound is the largest position value, so the full counter range is used.
- R11: A home edge wins over an index edge, and both win over a count step in the same cycle. When home and index arrive together, both flags are still set.
- R12: With `idx_en` or `rst_en` low, edges on the matching input change neither the counters nor the flags.
- R13: After reset, the position, `cycles`, both bounds, the start value and the flags are 0, and the compare register holds all ones. Write addresses: 0 position, 1 cycles, 2 lower bound, 3 upper bound, 4 start value, 5 compare, 6 flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | Quadrature phase A, asynchronous |
| in_b | input | 1 | Quadrature phase B, asynchronous |
| in_index | input | 1 | Index strobe, asynchronous |
| in_reset | input | 1 | Home strobe, asynchronous |
| res_sel | input | 2 | Counts per quadrature cycle select |
| filt_len | input | FILT_W | Glitch filter stability count |
| idx_en | input | 1 | Enables the index strobe |
| rst_en | input | 1 | Enables the home strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | WR_W | Register write data |
| pos | output | POS_W | Position count |
| cycles | output | CYC_W | Signed wrap counter |
| cyc_prev | output | CYC_W | `cycles` value before the last write to it |
| match_out | output | 1 | High while position equals compare value |
| flags | output | 5 | Sticky flags: home, index, match, roll-over, roll-under |

## Verification
The assertions rely on a few assumptions about the inputs:
- The configuration (`res_sel`, `filt_len`, the enables and the window) is held steady while phases move.
- The encoder advances at most one phase per accepted change.
- The write port names only the seven defined addresses.

The stimulus changes inputs only on falling clock edges and moves the phase pair one step at a time. After each change it waits long enough for the synchroniser, the filter and the counter to settle before the next change. Simultaneous events are created on purpose: index together with home, and index together with a phase step. These are the only cases where the bench exercises the priority rules.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
  typedef enum logic [2:0] {
    ADDR_POS   = 3'd0,
    ADDR_CYC   = 3'd1,
    ADDR_LO    = 3'd2,
    ADDR_HI    = 3'd3,
    ADDR_START = 3'd4,
    ADDR_CMP   = 3'd5,
    ADDR_CLR   = 3'd6
  } qpos_addr_e;

  localparam int EV_HOME  = 0;
  localparam int EV_INDEX = 1;
  localparam int EV_MATCH = 2;
  localparam int EV_OVER  = 3;
  localparam int EV_UNDER = 4;
  localparam int EV_N     = 5;

  localparam logic [1:0] RES_X1 = 2'd0;
  localparam logic [1:0] RES_X2 = 2'd1;
endpackage

// File: rtl/qpos_in_filter.sv
module qpos_in_filter #(
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raw,
  input  logic [FILT_W-1:0] thr,
  output logic              clean
);
  logic s1_q, s2_q, clean_q;
  logic [FILT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      clean_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
      if (s2_q == clean_q) begin
        cnt_q <= '0;
      end else if (cnt_q >= thr) begin
        clean_q <= s2_q;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign clean = clean_q;

  // R9: an input that agrees with the accepted level cannot move it
  p_hold_when_equal_r9: assert property (@(posedge clk) disable iff (rst)
    (s2_q == clean_q) |=> (clean_q == $past(clean_q)));
  // R9: a zero stability count passes the synchronised level straight on
  p_bypass_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (thr == '0) |=> (clean_q == $past(s2_q)));
endmodule

// File: rtl/qpos_quad_dec.sv
module qpos_quad_dec
  import qpos_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       a,
  input  logic       b,
  input  logic [1:0] res,
  output logic       step_up,
  output logic       step_dn,
  output logic       move_up,
  output logic       move_dn
);
  logic [1:0] ph_q, ph_n, delta;
  logic       a_was, a_now, gate_up, gate_dn;

  // phase index: 00->0, 01->1 (A high), 11->2, 10->3 for {B,A}
  assign ph_n  = {b, a ^ b};
  assign delta = ph_n - ph_q;
  assign a_was = ph_q[1] ^ ph_q[0];
  assign a_now = ph_n[1] ^ ph_n[0];

  always_comb begin
    if (res == RES_X1) begin
      gate_up = (ph_q == 2'd0) && (ph_n == 2'd1);
      gate_dn = (ph_q == 2'd1) && (ph_n == 2'd0);
    end else if (res == RES_X2) begin
      gate_up = (a_was != a_now);
      gate_dn = (a_was != a_now);
    end else begin
      gate_up = 1'b1;
      gate_dn = 1'b1;
    end
  end

  assign move_up = (delta == 2'd1);
  assign move_dn = (delta == 2'd3);
  assign step_up = move_up && gate_up;
  assign step_dn = move_dn && gate_dn;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= 2'd0;
    else     ph_q <= ph_n;
  end

  // R1: never both directions at once
  p_one_way_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({step_up, step_dn}));
  // R1: single resolution only counts when leaving phase 0 upward
  p_x1_origin_r1: assert property (@(posedge clk) disable iff (rst)
    (res == RES_X1 && step_up) |-> (ph_q == 2'd0));
endmodule

// File: rtl/qpos_core.sv
module qpos_core
  import qpos_pkg::*;
#(
  parameter int POS_W = 32,
  parameter int CYC_W = 16,
  parameter int WR_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             move_up,
  input  logic             move_dn,
  input  logic             idx_lvl,
  input  logic             home_lvl,
  input  logic             idx_en,
  input  logic             rst_en,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [WR_W-1:0]  wr_data,
  output logic [POS_W-1:0] pos,
  output logic [CYC_W-1:0] cycles,
  output logic [CYC_W-1:0] cyc_prev,
  output logic             match_out,
  output logic [EV_N-1:0]  flags
);
  logic [POS_W-1:0] pos_q, pos_n, lo_q, hi_q, start_q, cmp_q, hi_eff;
  logic [CYC_W-1:0] cyc_q, cyc_n, prev_q;
  logic [EV_N-1:0]  flg_q, ev, clr;
  logic             dir_up_q, idx_q, home_q, idx_ev, home_ev;
  logic             wr_pos, wr_cyc;

  assign hi_eff  = (lo_q == '0 && hi_q == '0) ? {POS_W{1'b1}} : hi_q;
  assign idx_ev  = idx_en && idx_lvl && !idx_q;
  assign home_ev = rst_en && home_lvl && !home_q;
  assign wr_pos  = wr_en && (wr_addr == ADDR_POS);
  assign wr_cyc  = wr_en && (wr_addr == ADDR_CYC);
  assign clr     = (wr_en && wr_addr == ADDR_CLR) ? wr_data[EV_N-1:0] : '0;
  assign match_out = (pos_q == cmp_q);

  always_comb begin
    pos_n = pos_q;
    cyc_n = cyc_q;
    ev    = '0;
    ev[EV_MATCH] = match_out;
    if (home_ev) begin
      pos_n = start_q;
      ev[EV_HOME] = 1'b1;
    end
    if (idx_ev) begin
      ev[EV_INDEX] = 1'b1;
      if (!home_ev) begin
        pos_n = lo_q;
        cyc_n = dir_up_q ? cyc_q + 1'b1 : cyc_q - 1'b1;
      end
    end
    if (!home_ev && !idx_ev) begin
      if (step_up) begin
        if (pos_q >= hi_eff) begin
          pos_n = start_q;
          cyc_n = cyc_q + 1'b1;
          ev[EV_OVER] = 1'b1;
        end else begin
          pos_n = pos_q + 1'b1;
        end
      end else if (step_dn) begin
        if (pos_q <= lo_q) begin
          pos_n = hi_eff;
          cyc_n = cyc_q - 1'b1;
          ev[EV_UNDER] = 1'b1;
        end else begin
          pos_n = pos_q - 1'b1;
        end
      end
    end
    if (wr_pos) pos_n = wr_data[POS_W-1:0];
    if (wr_cyc) cyc_n = wr_data[CYC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      cyc_q    <= '0;
      prev_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      start_q  <= '0;
      cmp_q    <= {POS_W{1'b1}};
      flg_q    <= '0;
      dir_up_q <= 1'b1;
      idx_q    <= 1'b0;
      home_q   <= 1'b0;
    end else begin
      pos_q  <= pos_n;
      cyc_q  <= cyc_n;
      flg_q  <= (flg_q & ~clr) | ev;
      idx_q  <= idx_lvl;
      home_q <= home_lvl;
      if (move_up)      dir_up_q <= 1'b1;
      else if (move_dn) dir_up_q <= 1'b0;
      if (wr_cyc) prev_q <= cyc_q;
      if (wr_en && wr_addr == ADDR_LO)    lo_q    <= wr_data[POS_W-1:0];
      if (wr_en && wr_addr == ADDR_HI)    hi_q    <= wr_data[POS_W-1:0];
      if (wr_en && wr_addr == ADDR_START) start_q <= wr_data[POS_W-1:0];
      if (wr_en && wr_addr == ADDR_CMP)   cmp_q   <= wr_data[POS_W-1:0];
    end
  end

  assign pos      = pos_q;
  assign cycles   = cyc_q;
  assign cyc_prev = prev_q;
  assign flags    = flg_q;

  // R2: wrap at the top bumps the wrap counter and raises roll-over
  p_over_r2: assert property (@(posedge clk) disable iff (rst)
    (step_up && !home_ev && !idx_ev && pos_q >= hi_eff && !wr_pos && !wr_cyc)
    |=> (cyc_q == CYC_W'($past(cyc_q) + 1'b1)) && flg_q[EV_OVER]);
  // R3: wrap at the bottom lands on the effective upper bound
  p_under_r3: assert property (@(posedge clk) disable iff (rst)
    (step_dn && !home_ev && !idx_ev && pos_q <= lo_q && !wr_pos && !wr_cyc)
    |=> (pos_q == $past(hi_eff)) && flg_q[EV_UNDER]);
  // R5: accepted index edge snaps to the lower bound
  p_index_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (idx_ev && !home_ev && !wr_pos) |=> (pos_q == $past(lo_q)) && flg_q[EV_INDEX]);
  // R6: home edge reloads the start value and keeps the wrap counter
  p_home_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (home_ev && !wr_pos && !wr_cyc)
    |=> (pos_q == $past(start_q)) && (cyc_q == $past(cyc_q)));
  // R7: a match cycle leaves the match flag set
  p_match_flag_r7: assert property (@(posedge clk) disable iff (rst)
    match_out |=> flg_q[EV_MATCH]);
  // R8: flags only fall through an explicit clear write
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == ADDR_CLR) |=> (($past(flg_q) & ~flg_q) == '0));
  // R4: a wrap counter write never moves the position by itself
  p_cyc_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_cyc && !wr_pos && !home_ev && !idx_ev && !step_up && !step_dn)
    |=> (pos_q == $past(pos_q)) && (cyc_prev == $past(cyc_q)));
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int POS_W  = 32,
  parameter int CYC_W  = 16,
  parameter int FILT_W = 8,
  parameter int WR_W   = (POS_W > CYC_W) ? POS_W : CYC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              in_index,
  input  logic              in_reset,
  input  logic [1:0]        res_sel,
  input  logic [FILT_W-1:0] filt_len,
  input  logic              idx_en,
  input  logic              rst_en,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  output logic [POS_W-1:0]  pos,
  output logic [CYC_W-1:0]  cycles,
  output logic [CYC_W-1:0]  cyc_prev,
  output logic              match_out,
  output logic [4:0]        flags
);
  localparam int N_IN = 4;

  logic [N_IN-1:0] raw_in, clean_in;
  logic step_up, step_dn, move_up, move_dn;

  assign raw_in = {in_reset, in_index, in_b, in_a};

  for (genvar g = 0; g < N_IN; g++) begin : g_filt
    qpos_in_filter #(.FILT_W(FILT_W)) filt_i (
      .clk   (clk),
      .rst   (rst),
      .raw   (raw_in[g]),
      .thr   (filt_len),
      .clean (clean_in[g])
    );
  end

  qpos_quad_dec dec_i (
    .clk     (clk),
    .rst     (rst),
    .a       (clean_in[0]),
    .b       (clean_in[1]),
    .res     (res_sel),
    .step_up (step_up),
    .step_dn (step_dn),
    .move_up (move_up),
    .move_dn (move_dn)
  );

  qpos_core #(.POS_W(POS_W), .CYC_W(CYC_W), .WR_W(WR_W)) core_i (
    .clk       (clk),
    .rst       (rst),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .move_up   (move_up),
    .move_dn   (move_dn),
    .idx_lvl   (clean_in[2]),
    .home_lvl  (clean_in[3]),
    .idx_en    (idx_en),
    .rst_en    (rst_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pos       (pos),
    .cycles    (cycles),
    .cyc_prev  (cyc_prev),
    .match_out (match_out),
    .flags     (flags)
  );
endmodule

// File: tb/qpos_counter_tb_top.sv
module qpos_counter_tb_top;
  localparam int POS_W  = 8;
  localparam int CYC_W  = 16;
  localparam int FILT_W = 4;
  localparam int WR_W   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 0, in_b = 0, in_index = 0, in_reset = 0;
  logic [1:0] res_sel = 2'd2;
  logic [FILT_W-1:0] filt_len = '0;
  logic idx_en = 0, rst_en = 0, wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [WR_W-1:0] wr_data = '0;
  logic [POS_W-1:0] pos;
  logic [CYC_W-1:0] cycles, cyc_prev;
  logic match_out;
  logic [4:0] flags;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  int mpos, mmin, mmax, minit;
  logic [15:0] mcyc;
  bit mdir = 1;
  logic [1:0] ph = 2'd0;

  always #2 clk = ~clk;

  qpos_counter #(.POS_W(POS_W), .CYC_W(CYC_W), .FILT_W(FILT_W), .WR_W(WR_W)) dut_i (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_index(in_index),
    .in_reset(in_reset), .res_sel(res_sel), .filt_len(filt_len),
    .idx_en(idx_en), .rst_en(rst_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pos(pos), .cycles(cycles), .cyc_prev(cyc_prev),
    .match_out(match_out), .flags(flags)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = WR_W'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic model_step(input bit up);
    if (up) begin
      if (mpos >= mmax) begin mpos = minit; mcyc = mcyc + 1'b1; end
      else mpos = mpos + 1;
    end else begin
      if (mpos <= mmin) begin mpos = mmax; mcyc = mcyc - 1'b1; end
      else mpos = mpos - 1;
    end
  endtask

  task automatic qstep(input bit up, input bit with_idx);
    logic [1:0] pn;
    bit cnt;
    pn = up ? ph + 2'd1 : ph - 2'd1;
    case (res_sel)
      2'd0: cnt = up ? (ph == 2'd0 && pn == 2'd1) : (ph == 2'd1 && pn == 2'd0);
      2'd1: cnt = ((ph[0] ^ ph[1]) != (pn[0] ^ pn[1]));
      default: cnt = 1;
    endcase
    if (with_idx) begin
      mpos = mmin;
      mcyc = mdir ? mcyc + 1'b1 : mcyc - 1'b1;
    end else if (cnt) begin
      model_step(up);
    end
    mdir = up;
    ph = pn;
    @(negedge clk);
    in_b = pn[1];
    in_a = pn[1] ^ pn[0];
    if (with_idx) in_index = 1;
    settle(8);
  endtask

  task automatic pulse_idx(input int len);
    @(negedge clk);
    in_index = 1;
    settle(len);
    in_index = 0;
    settle(12);
  endtask

  task automatic pulse_home;
    @(negedge clk);
    in_reset = 1;
    settle(8);
    in_reset = 0;
    settle(8);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    settle(4);
    rst = 0;
    settle(2);
    // R13 reset state
    chk("R13 pos", int'(pos), 0);
    chk("R13 cycles", int'(cycles), 0);
    chk("R13 flags", int'(flags), 0);
    chk("R13 match_out", int'(match_out), 0);

    // window 2..9, start 3
    mmin = 2; mmax = 9; minit = 3; mcyc = 16'd0;
    wr(3'd2, 2); wr(3'd3, 9); wr(3'd4, 3);
    for (int r = 0; r < 3; r++) begin
      res_sel = 2'(r);
      wr(3'd0, 3); mpos = 3;
      wr(3'd1, 0); mcyc = 16'd0;
      for (int i = 0; i < 40; i++) begin
        qstep(1, 0);
        chk("R1/R2 fwd pos", int'(pos), mpos);
        chk("R1/R2 fwd cycles", int'(cycles), int'(mcyc));
      end
      for (int i = 0; i < 40; i++) begin
        qstep(0, 0);
        chk("R1/R3 rev pos", int'(pos), mpos);
        chk("R1/R3 rev cycles", int'(cycles), int'(mcyc));
      end
    end
    chk("R2 roll-over flag", int'(flags[3]), 1);
    chk("R3 roll-under flag", int'(flags[4]), 1);

    // R4 cycles write
    wr(3'd1, 16'h1234);
    settle(1);
    chk("R4 cycles loaded", int'(cycles), 16'h1234);
    chk("R4 previous value", int'(cyc_prev), int'(mcyc));
    chk("R4 pos unchanged", int'(pos), mpos);
    mcyc = 16'h1234;

    // R8 clear, R7 match
    wr(3'd6, 5'h1F);
    settle(1);
    chk("R8 flags cleared", int'(flags), 0);
    wr(3'd5, mpos);
    settle(1);
    chk("R7 match high", int'(match_out), 1);
    chk("R7 match flag", int'(flags[2]), 1);
    wr(3'd6, 5'h1F);
    settle(1);
    chk("R8 set beats clear", int'(flags[2]), 1);
    wr(3'd5, 200); wr(3'd0, 200);
    settle(1);
    chk("R7 match outside window", int'(match_out), 1);
    wr(3'd0, 5); mpos = 5;
    settle(1);
    chk("R7 match low", int'(match_out), 0);
    wr(3'd6, 5'h1F);

    // R5 index, last direction down
    idx_en = 1;
    pulse_idx(6);
    chk("R5 index pos", int'(pos), 2);
    chk("R5 index cycles down", int'(cycles), 16'h1233);
    chk("R5 index flag", int'(flags[1]), 1);
    mpos = 2; mcyc = 16'h1233;
    qstep(1, 0);
    pulse_idx(6);
    chk("R5 index cycles up", int'(cycles), 16'h1234);
    mpos = 2; mcyc = 16'h1234;

    // R6 home
    qstep(1, 0); qstep(1, 0);
    rst_en = 1;
    pulse_home();
    chk("R6 home pos", int'(pos), 3);
    chk("R6 home cycles", int'(cycles), 16'h1234);
    chk("R6 home flag", int'(flags[0]), 1);
    mpos = 3;

    // R12 disabled inputs
    qstep(1, 0);
    wr(3'd6, 5'h1F);
    idx_en = 0; rst_en = 0;
    pulse_idx(6);
    pulse_home();
    chk("R12 pos kept", int'(pos), mpos);
    chk("R12 cycles kept", int'(cycles), int'(mcyc));
    chk("R12 flags idle", int'(flags[1:0]), 0);

    // R11 home beats index
    idx_en = 1; rst_en = 1;
    @(negedge clk);
    in_index = 1; in_reset = 1;
    settle(8);
    in_index = 0; in_reset = 0;
    settle(8);
    chk("R11 home wins pos", int'(pos), 3);
    chk("R11 cycles untouched", int'(cycles), int'(mcyc));
    chk("R11 both flags", int'(flags[1:0]), 3);
    mpos = 3;
    // R11 index beats a step in the same cycle
    qstep(1, 0);
    qstep(1, 1);
    chk("R11 index over step pos", int'(pos), mpos);
    chk("R11 index over step cycles", int'(cycles), int'(mcyc));
    in_index = 0;
    settle(8);

    // R10 full range
    wr(3'd2, 0); wr(3'd3, 0);
    mmin = 0; mmax = 255;
    wr(3'd0, 254); mpos = 254;
    qstep(1, 0);
    chk("R10 reach top", int'(pos), 255);
    qstep(1, 0);
    chk("R10 wrap to start", int'(pos), 3);
    chk("R10 wrap cycles", int'(cycles), int'(mcyc));
    wr(3'd0, 0); mpos = 0;
    qstep(0, 0);
    chk("R10 under to top", int'(pos), 255);
    chk("R10 under cycles", int'(cycles), int'(mcyc));

    // R9 filter: stability 3 needs 4 clocks
    filt_len = 4'd3;
    wr(3'd2, 7); mmin = 7;
    wr(3'd0, 20); mpos = 20;
    pulse_idx(3);
    chk("R9 short pulse dropped", int'(pos), 20);
    pulse_idx(4);
    chk("R9 long pulse accepted", int'(pos), 7);
    filt_len = '0;

    done = 1;
    report();
  end
endmodule